// File: doc/BRIEF.md
# Shift-and-Move Unit with Condition Flags

This block is the shift stage of a 32-bit integer execute pipeline. It takes one operand and shifts or rotates it by an amount that comes either from a small immediate or from the low byte of a register. The result can be bit-inverted to serve move-not operations. When flag update is requested, the unit also works out the next negative, zero, carry and overflow flags.

The carry flag always receives the last bit that left the operand. It keeps its old value when nothing is shifted. The rotate-through-carry mode feeds the incoming carry into the top bit. Overflow is never altered.

One register stage holds the result and the flags, so outputs appear one clock after the inputs. Decode, the register file and condition evaluation sit elsewhere in the pipeline.

Top module: `shift_flag_unit`

## Requirements
- R1: Result and flags are registered: inputs sampled at one rising clock edge appear on the outputs after that edge. An active-low asynchronous reset clears the result and all four flags to zero.
- R2: With `amt_from_reg_i` high, the shift amount is the full 8-bit `amt_reg_i` (0 to 255). Otherwise it is the 5-bit `amt_imm_i`, zero-extended.
- R3: Kind code 0 (left logical) fills with zeros, and the carry is the last bit shifted out. An amount of exactly 32 gives a zero result with carry equal to operand bit 0. An amount above 32 gives zero with carry cleared.
- R4: Kind code 1 (right logical) fills the top with zeros, and the carry is the last bit shifted out. Exactly 32 gives zero with carry equal to operand bit 31. An amount above 32 gives zero with carry cleared.
- R5: Kind code 2 (right arithmetic) fills the top with copies of operand bit 31, and the carry is the last bit shifted out. An amount of 32 or more gives all bits equal to operand bit 31, with carry equal to bit 31.
- R6: Kind code 3 (rotate right) moves bits leaving bit 0 back in at bit 31, and the carry is the last bit rotated, which is result bit 31. A non-zero multiple of 32 leaves the value unchanged, with carry equal to operand bit 31.
- R7: Kind code 4 (one-bit rotate through carry) gives {carry_in, operand[31:1]}, and the new carry is operand bit 0. The shift amount is ignored in this mode.
- R8: An amount of zero with kind codes 0 to 3, or any amount with the unused kind codes 5 to 7, passes the operand through unshifted, and the carry keeps its input value.
- R9: With `invert_i` high, the result is the bitwise NOT of the shifted value. N and Z are computed from the inverted value, while C still comes from the shift.
- R10: With `set_flags_i` high, N equals result bit 31 and Z is set exactly when the result is zero.
- R11: V out always equals V in.
- R12: With `set_flags_i` low, all four output flags equal the input flags. The flags are packed as bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| operand_i | input | 32 | Value to shift |
| kind_i | input | 3 | Shift kind code (0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 RRX) |
| amt_from_reg_i | input | 1 | Selects the register amount instead of the immediate |
| amt_imm_i | input | 5 | Immediate shift amount |
| amt_reg_i | input | 8 | Low byte of the amount register |
| set_flags_i | input | 1 | Enables flag update |
| invert_i | input | 1 | Inverts the shifted value (move-not) |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| result_o | output | 32 | Registered result |
| flags_o | output | 4 | Registered next flags {N,Z,C,V} |

## Verification
The clocked checks assume that every input is stable and known at each rising edge. They relate the registered outputs to the inputs of the previous edge, and they stay silent until one edge has passed outside reset.

The stimulus changes inputs only on falling edges and keeps one operation in flight per cycle, so each result can be matched in order against its expected value. The vectors cover every kind code, including the unused ones, and amounts of 0, 1, 31, 32, 33, multiples of 32 and 255 from both amount sources. Random operations follow, with flag update and inversion toggled.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  typedef enum logic [2:0] {
    SH_LSL = 3'd0,
    SH_LSR = 3'd1,
    SH_ASR = 3'd2,
    SH_ROR = 3'd3,
    SH_RRX = 3'd4
  } shift_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } cond_flags_t;
endpackage

// File: rtl/sfu_amount_sel.sv
module sfu_amount_sel #(
  parameter int IMM_W = 5,
  parameter int AMT_W = 8
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic [AMT_W-1:0] reg_i,
  input  logic             from_reg_i,
  output logic [AMT_W-1:0] amt_o,
  output logic             amt_zero_o
);
  always_comb begin
    amt_o      = from_reg_i ? reg_i : AMT_W'(imm_i);
    amt_zero_o = (amt_o == '0);
  end
endmodule

// File: rtl/sfu_barrel.sv
module sfu_barrel #(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic [W-1:0]     op_i,
  input  logic [2:0]       kind_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             cin_i,
  output logic [W-1:0]     res_o,
  output logic             cout_o
);
  import sfu_pkg::*;

  // Returns {carry, result}
  function automatic logic [W:0] shift_fn(input logic [W-1:0] op,
                                          input logic [2:0] kind,
                                          input logic [AMT_W-1:0] amt,
                                          input logic cin);
    int a;
    int r;
    logic [W-1:0] res;
    logic c;
    a   = int'(amt);
    r   = a % W;
    res = op;
    c   = cin;
    case (kind)
      SH_LSL: begin
        if (a == 0) begin
          res = op;
        end else if (a < W) begin
          res = op << a;
          c   = op[W-a];
        end else if (a == W) begin
          res = '0;
          c   = op[0];
        end else begin
          res = '0;
          c   = 1'b0;
        end
      end
      SH_LSR: begin
        if (a == 0) begin
          res = op;
        end else if (a < W) begin
          res = op >> a;
          c   = op[a-1];
        end else if (a == W) begin
          res = '0;
          c   = op[W-1];
        end else begin
          res = '0;
          c   = 1'b0;
        end
      end
      SH_ASR: begin
        if (a == 0) begin
          res = op;
        end else if (a < W) begin
          res = $signed(op) >>> a;
          c   = op[a-1];
        end else begin
          res = {W{op[W-1]}};
          c   = op[W-1];
        end
      end
      SH_ROR: begin
        if (a == 0) begin
          res = op;
        end else if (r == 0) begin
          res = op;
          c   = op[W-1];
        end else begin
          res = (op >> r) | (op << (W - r));
          c   = op[r-1];
        end
      end
      SH_RRX: begin
        res = {cin, op[W-1:1]};
        c   = op[0];
      end
      default: begin
        res = op;
      end
    endcase
    return {c, res};
  endfunction

  always_comb begin
    {cout_o, res_o} = shift_fn(op_i, kind_i, amt_i, cin_i);
  end
endmodule

// File: rtl/sfu_flag_gen.sv
module sfu_flag_gen #(
  parameter int W = 32
) (
  input  logic [W-1:0]             shifted_i,
  input  logic                     cout_i,
  input  logic                     invert_i,
  input  logic                     set_i,
  input  sfu_pkg::cond_flags_t     flags_i,
  output logic [W-1:0]             res_o,
  output sfu_pkg::cond_flags_t     flags_o
);
  function automatic sfu_pkg::cond_flags_t next_flags(input logic [W-1:0] res,
                                                      input logic c,
                                                      input logic set,
                                                      input sfu_pkg::cond_flags_t f);
    sfu_pkg::cond_flags_t nf;
    nf = f;
    if (set) begin
      nf.n = res[W-1];
      nf.z = (res == '0);
      nf.c = c;
    end
    return nf;
  endfunction

  always_comb begin
    res_o   = invert_i ? ~shifted_i : shifted_i;
    flags_o = next_flags(res_o, cout_i, set_i, flags_i);
  end
endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit #(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [W-1:0]           operand_i,
  input  logic [2:0]             kind_i,
  input  logic                   amt_from_reg_i,
  input  logic [$clog2(W)-1:0]   amt_imm_i,
  input  logic [AMT_W-1:0]       amt_reg_i,
  input  logic                   set_flags_i,
  input  logic                   invert_i,
  input  logic [3:0]             flags_i,
  output logic [W-1:0]           result_o,
  output logic [3:0]             flags_o
);
  import sfu_pkg::*;

  localparam int IMM_W = $clog2(W);

  logic [AMT_W-1:0] amt_w;
  logic             amt_zero_w;
  logic [W-1:0]     shifted_w;
  logic             carry_w;
  logic [W-1:0]     final_w;
  cond_flags_t      flags_in_w;
  cond_flags_t      flags_next_w;
  cond_flags_t      flags_q;
  logic [W-1:0]     result_q;
  logic             out_live;

  assign flags_in_w = cond_flags_t'(flags_i);

  sfu_amount_sel #(.IMM_W(IMM_W), .AMT_W(AMT_W)) u_amt (
    .imm_i      (amt_imm_i),
    .reg_i      (amt_reg_i),
    .from_reg_i (amt_from_reg_i),
    .amt_o      (amt_w),
    .amt_zero_o (amt_zero_w)
  );

  sfu_barrel #(.W(W), .AMT_W(AMT_W)) u_shift (
    .op_i   (operand_i),
    .kind_i (kind_i),
    .amt_i  (amt_w),
    .cin_i  (flags_in_w.c),
    .res_o  (shifted_w),
    .cout_o (carry_w)
  );

  sfu_flag_gen #(.W(W)) u_flags (
    .shifted_i (shifted_w),
    .cout_i    (carry_w),
    .invert_i  (invert_i),
    .set_i     (set_flags_i),
    .flags_i   (flags_in_w),
    .res_o     (final_w),
    .flags_o   (flags_next_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      flags_q  <= '0;
      out_live <= 1'b0;
    end else begin
      result_q <= final_w;
      flags_q  <= flags_next_w;
      out_live <= 1'b1;
    end
  end

  assign result_o = result_q;
  assign flags_o  = flags_q;

  // R11
  v_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_live |-> (flags_q.v == $past(flags_i[0])));

  // R12
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_live && !$past(set_flags_i)) |-> (flags_q == $past(flags_i)));

  // R10
  n_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_live && $past(set_flags_i)) |-> (flags_q.n == result_q[W-1]));

  // R10
  z_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_live && $past(set_flags_i)) |-> (flags_q.z == (result_q == '0)));

  // R8
  zero_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_live && $past(set_flags_i) && $past(amt_zero_w) && !$past(invert_i)
     && ($past(kind_i) != 3'd4))
    |-> ((flags_q.c == $past(flags_i[1])) && (result_q == $past(operand_i))));

  // R7
  rrx_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_live && $past(set_flags_i) && ($past(kind_i) == 3'd4))
    |-> (flags_q.c == $past(operand_i[0])));
endmodule

// File: tb/sim_shift_flag_unit.sv
`timescale 1ns/1ps
module sim_shift_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] operand_i;
  logic [2:0]  kind_i;
  logic        amt_from_reg_i;
  logic [4:0]  amt_imm_i;
  logic [7:0]  amt_reg_i;
  logic        set_flags_i;
  logic        invert_i;
  logic [3:0]  flags_i;
  logic [31:0] result_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [31:0] res;
    logic [3:0]  fl;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  shift_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .operand_i(operand_i), .kind_i(kind_i),
    .amt_from_reg_i(amt_from_reg_i), .amt_imm_i(amt_imm_i), .amt_reg_i(amt_reg_i),
    .set_flags_i(set_flags_i), .invert_i(invert_i), .flags_i(flags_i),
    .result_o(result_o), .flags_o(flags_o)
  );

  // Bit-at-a-time reference: each step moves one bit and records what left.
  function automatic logic [35:0] model(input logic [31:0] op, input logic [2:0] kind,
                                        input logic from_reg, input logic [4:0] imm,
                                        input logic [7:0] ramt, input logic set,
                                        input logic inv, input logic [3:0] fl);
    logic [31:0] r;
    logic c;
    logic t;
    int n;
    n = from_reg ? int'(ramt) : int'(imm);
    r = op;
    c = fl[1];
    if (kind == 3'd4) begin
      t = r[0];
      r = {c, r[31:1]};
      c = t;
    end else if (kind < 3'd4) begin
      for (int i = 0; i < n; i++) begin
        case (kind)
          3'd0: begin c = r[31]; r = {r[30:0], 1'b0}; end
          3'd1: begin c = r[0];  r = {1'b0, r[31:1]}; end
          3'd2: begin c = r[0];  r = {r[31], r[31:1]}; end
          default: begin c = r[0]; r = {r[0], r[31:1]}; end
        endcase
      end
    end
    if (inv) r = ~r;
    if (set) return {r[31], (r == 32'd0), c, fl[0], r};
    return {fl, r};
  endfunction

  task automatic drive(input string tag, input logic [31:0] op, input logic [2:0] kind,
                       input logic from_reg, input logic [4:0] imm, input logic [7:0] ramt,
                       input logic set, input logic inv, input logic [3:0] fl);
    exp_t e;
    logic [35:0] m;
    @(negedge clk);
    operand_i = op; kind_i = kind; amt_from_reg_i = from_reg; amt_imm_i = imm;
    amt_reg_i = ramt; set_flags_i = set; invert_i = inv; flags_i = fl;
    m = model(op, kind, from_reg, imm, ramt, set, inv, fl);
    e.res = m[31:0];
    e.fl  = m[35:32];
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic hand(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: results leave the register one edge after the driver's falling edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (result_o !== e.res || flags_o !== e.fl) begin
          fails++;
          $display("FAIL %s actual res=%h fl=%b expected res=%h fl=%b",
                   e.tag, result_o, flags_o, e.res, e.fl);
        end
      end
    end
  end

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  localparam logic [31:0] OPA = 32'hFDB97531;
  localparam logic [3:0]  F0  = 4'b1001;

  initial begin
    rst_n = 1'b0;
    operand_i = '0; kind_i = '0; amt_from_reg_i = 0; amt_imm_i = '0;
    amt_reg_i = '0; set_flags_i = 0; invert_i = 0; flags_i = '0;
    repeat (3) @(negedge clk);
    hand("R1 reset result", result_o, 32'd0);
    hand("R1 reset flags", {28'd0, flags_o}, 32'd0);
    rst_n = 1'b1;
    // R1: output follows one edge after the drive
    drive("R1 move imm", 32'h00000FAB, 3'd0, 0, 5'd0, 8'd0, 1, 0, F0);
    drive("R8 zero amount carry kept", OPA, 3'd0, 0, 5'd0, 8'd0, 1, 0, 4'b0011);
    drive("R5 asr 3", OPA, 3'd2, 0, 5'd3, 8'd0, 1, 0, F0);
    drive("R9 invert imm", 32'h000002FC, 3'd0, 0, 5'd0, 8'd0, 1, 1, F0);
    drive("R3 R9 lsl reg 12 inverted", OPA, 3'd0, 1, 5'd0, 8'd12, 1, 1, F0);
    drive("R7 rrx", OPA, 3'd4, 0, 5'd0, 8'd0, 1, 0, F0);
    drive("R7 rrx amount ignored", OPA, 3'd4, 1, 5'd0, 8'd77, 1, 0, 4'b0011);
    drive("R6 ror 5", OPA, 3'd3, 0, 5'd5, 8'd0, 1, 0, F0);
    drive("R4 lsr reg 12", OPA, 3'd1, 1, 5'd0, 8'd12, 1, 0, F0);
    drive("R9 plain invert", OPA, 3'd0, 0, 5'd0, 8'd0, 1, 1, F0);
    drive("R3 lsl 1", 32'h80000001, 3'd0, 0, 5'd1, 8'd0, 1, 0, F0);
    drive("R3 lsl 31", 32'h00000003, 3'd0, 0, 5'd31, 8'd0, 1, 0, F0);
    drive("R3 lsl 32", 32'h00000001, 3'd0, 1, 5'd0, 8'd32, 1, 0, F0);
    drive("R3 lsl 33", 32'hFFFFFFFF, 3'd0, 1, 5'd0, 8'd33, 1, 0, 4'b0011);
    drive("R4 lsr 32", 32'h80000000, 3'd1, 1, 5'd0, 8'd32, 1, 0, F0);
    drive("R4 lsr 255", 32'hFFFFFFFF, 3'd1, 1, 5'd0, 8'd255, 1, 0, 4'b0011);
    drive("R5 asr 32", 32'h80000000, 3'd2, 1, 5'd0, 8'd32, 1, 0, F0);
    drive("R5 asr 200 positive", 32'h7FFFFFFF, 3'd2, 1, 5'd0, 8'd200, 1, 0, 4'b0011);
    drive("R6 ror 32", OPA, 3'd3, 1, 5'd0, 8'd32, 1, 0, F0);
    drive("R6 ror 64", 32'h12345678, 3'd3, 1, 5'd0, 8'd64, 1, 0, 4'b0011);
    drive("R6 ror 37", OPA, 3'd3, 1, 5'd0, 8'd37, 1, 0, F0);
    drive("R2 reg amount selected over imm", OPA, 3'd1, 1, 5'd4, 8'd8, 1, 0, F0);
    drive("R2 imm amount selected over reg", OPA, 3'd1, 0, 5'd4, 8'd8, 1, 0, F0);
    drive("R8 reg amount zero", OPA, 3'd2, 1, 5'd9, 8'd0, 1, 0, 4'b0010);
    drive("R8 unused kind 5", OPA, 3'd5, 0, 5'd7, 8'd0, 1, 0, 4'b0010);
    drive("R8 unused kind 7", 32'h0, 3'd7, 1, 5'd0, 8'd9, 1, 0, 4'b1001);
    drive("R10 zero result Z", 32'h00000001, 3'd1, 0, 5'd1, 8'd0, 1, 0, 4'b1000);
    drive("R10 invert to zero", 32'hFFFFFFFF, 3'd0, 0, 5'd0, 8'd0, 1, 1, 4'b0000);
    drive("R11 V clear passes", OPA, 3'd3, 0, 5'd9, 8'd0, 1, 0, 4'b0110);
    drive("R12 no flag update", OPA, 3'd1, 0, 5'd4, 8'd0, 0, 0, 4'b0110);
    drive("R12 no flag update invert", 32'h0, 3'd0, 0, 5'd0, 8'd0, 0, 1, 4'b1011);
    for (int k = 0; k < 400; k++) begin
      drive("R3 R4 R5 R6 R7 R9 R10 random", $urandom, 3'($urandom_range(0, 7)),
            1'($urandom), 5'($urandom), 8'($urandom_range(0, 70)),
            1'($urandom), 1'($urandom), 4'($urandom));
    end
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule